// File: doc/BRIEF.md
# Fragmenting Message Writer for a Slot Ring

This block moves one byte message into a circular buffer that holds 32-bit slots and is drained by a peer. The message arrives as a byte stream whose total length is given when the send starts. The block splits the message into fragments. Each fragment is one header slot followed by its payload, packed four bytes to a slot. After each fragment the block raises a one-cycle request that interrupts the peer. It then confirms that the peer still reports ready before it goes on.

The buffer depth in slots is an input. The largest fragment payload is whichever is smaller, the buffer size in bytes or 511 (the largest value the 9-bit length field can hold), minus the 4 bytes kept for the header. Before each header and before each payload, the block waits until the buffer reports enough free slots. It tests the free count once at entry and then every `POLL_INTERVAL` cycles. It abandons the send after `TIMEOUT_POLLS` polls that all fail. At the default values this is 5 s at 100 MHz. Every send ends with a one-cycle done pulse that carries a success flag, and the block then returns to idle.

Top module: `msg_frag_tx`

## Requirements
- R1: A header slot is laid out as: bit 31 complete flag, bits 30:25 zero, bits 24:16 fragment payload length in bytes, bits 15:8 host address, bits 7:0 client address.
- R2: Each fragment carries min(remaining, cap) bytes, where cap = min(4*buf_depth_i, 511) - 4. A start with buf_depth_i below 2 (cap 0) is rejected: done with failure and no slot written.
- R3: Only the fragment that carries the last remaining bytes of the message has the complete flag set.
- R4: A header is written only after a poll sees slot_free_i >= 1. While no poll succeeds, nothing is written.
- R5: A payload is written only after a poll sees slot_free_i >= ceil(len/4), where len is that fragment's length. Until then the header is the only slot of the fragment in the buffer.
- R6: Payload bytes are packed little-endian (stream byte k of a slot goes to bits 8k+7:8k). Whole slots come first, then 1 to 3 leftover bytes go into one further slot whose unused upper bytes are zero.
- R7: irq_gen_o pulses for exactly one cycle per fragment, in the cycle in which the fragment's last slot appears on the write port.
- R8: If peer_ready_i is low in the cycle after an irq_gen_o pulse, the send ends in failure and no further slot is written.
- R9: A start with msg_len_i equal to zero gives done_o with ok_o low in the next cycle, and no slot is written.
- R10: Free space is polled at entry to a wait and then every POLL_INTERVAL cycles. After TIMEOUT_POLLS failed polls the send ends in failure, about (TIMEOUT_POLLS-1)*POLL_INTERVAL cycles after the wait began.
- R11: After reset the block is idle: no write, no request, no done. done_o is a one-cycle pulse, with ok_o high only when every fragment was sent. byte_ready_o and slot writes occur only while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a send; taken only while idle |
| msg_len_i | input | LEN_W | Total message length in bytes |
| host_addr_i | input | 8 | Host address copied into each header |
| client_addr_i | input | 8 | Client address copied into each header |
| buf_depth_i | input | CNT_W | Ring depth in slots |
| byte_valid_i | input | 1 | Stream byte present |
| byte_data_i | input | 8 | Stream byte |
| byte_ready_o | output | 1 | Block takes the stream byte this cycle |
| slot_free_i | input | CNT_W | Free slots currently in the ring |
| peer_ready_i | input | 1 | Peer reports ready |
| slot_wr_o | output | 1 | Slot write strobe |
| slot_data_o | output | 32 | Slot write data |
| irq_gen_o | output | 1 | One-cycle request to interrupt the peer |
| busy_o | output | 1 | A send is in progress |
| done_o | output | 1 | One-cycle end-of-send pulse |
| ok_o | output | 1 | Send succeeded; valid with done_o |

## Verification
The assertions watch properties that must hold on every cycle. Request and done are single-cycle pulses. The last slot of a fragment coincides with its request. A header follows a successful poll. Polls are spaced apart. A zero-length start and a lost peer both end in failure, and the stream is taken only while busy. The header contents, the fragment split at the cap, the complete flag, the byte order and zero padding, and the cycles spent stalled on a short free count can only be shown by the bench. It compares whole slot streams against a model it computes itself, for directed boundary lengths and random messages.

// File: rtl/mft_pkg.sv
package mft_pkg;

  localparam int SLOT_W      = 32;
  localparam int LEN_FIELD_W = 9;
  localparam int ADDR_W      = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_HDR,
    ST_HDR,
    ST_WAIT_PAY,
    ST_PAY,
    ST_IRQ,
    ST_CHECK,
    ST_DONE
  } seq_state_t;

  // Largest payload per fragment: buffer bytes capped by the 9-bit field,
  // less one slot kept for the header. Zero means the ring is unusable.
  function automatic logic [LEN_FIELD_W-1:0] frag_cap(input logic [15:0] depth_slots);
    logic [17:0] ring_bytes;
    logic [17:0] limited;
    ring_bytes = {depth_slots, 2'b00};
    limited    = (ring_bytes > 18'd511) ? 18'd511 : ring_bytes;
    if (limited < 18'd4) return '0;
    return LEN_FIELD_W'(limited - 18'd4);
  endfunction

  // Slots needed to hold nbytes of payload, rounded up.
  function automatic logic [7:0] slots_for(input logic [LEN_FIELD_W-1:0] nbytes);
    logic [LEN_FIELD_W:0] padded;
    padded = {1'b0, nbytes} + (LEN_FIELD_W+1)'(3);
    return padded[LEN_FIELD_W:2];
  endfunction

  function automatic logic [SLOT_W-1:0] build_header(
    input logic                   last_frag,
    input logic [LEN_FIELD_W-1:0] nbytes,
    input logic [ADDR_W-1:0]      host,
    input logic [ADDR_W-1:0]      client
  );
    return {last_frag, 6'b000000, nbytes, host, client};
  endfunction

endpackage

// File: rtl/mft_poll_timer.sv
module mft_poll_timer #(
  parameter int POLL_INTERVAL = 10000,
  parameter int TIMEOUT_POLLS = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic enough_i,
  output logic poll_o,
  output logic grant_o,
  output logic expire_o
);

  localparam int PW = (POLL_INTERVAL > 1) ? $clog2(POLL_INTERVAL + 1) : 1;
  localparam int MW = (TIMEOUT_POLLS > 1) ? $clog2(TIMEOUT_POLLS + 1) : 1;

  logic [PW-1:0] gap_q;
  logic [MW-1:0] miss_q;

  assign poll_o   = active_i && (gap_q == '0);
  assign grant_o  = poll_o && enough_i;
  assign expire_o = poll_o && !enough_i && (miss_q == MW'(TIMEOUT_POLLS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      miss_q <= '0;
    end else if (!active_i || grant_o || expire_o) begin
      gap_q  <= '0;
      miss_q <= '0;
    end else if (poll_o) begin
      miss_q <= miss_q + 1'b1;
      gap_q  <= PW'(POLL_INTERVAL - 1);
    end else begin
      gap_q  <= gap_q - 1'b1;
    end
  end

endmodule

// File: rtl/mft_packer.sv
module mft_packer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_i,
  input  logic        byte_valid_i,
  input  logic [7:0]  byte_data_i,
  input  logic        last_i,
  output logic        byte_ready_o,
  output logic        take_o,
  output logic        word_wr_o,
  output logic [31:0] word_o
);

  logic [31:0] acc_q;
  logic [1:0]  lane_q;
  logic [31:0] merged;

  assign byte_ready_o = en_i;
  assign take_o       = en_i && byte_valid_i;
  assign merged       = acc_q | (32'(byte_data_i) << {lane_q, 3'b000});
  assign word_wr_o    = take_o && ((lane_q == 2'd3) || last_i);
  assign word_o       = merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      lane_q <= '0;
    end else if (word_wr_o) begin
      acc_q  <= '0;
      lane_q <= '0;
    end else if (take_o) begin
      acc_q  <= merged;
      lane_q <= lane_q + 2'd1;
    end
  end

endmodule

// File: rtl/mft_seq.sv
module mft_seq
  import mft_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [LEN_W-1:0]    msg_len_i,
  input  logic [ADDR_W-1:0]   host_addr_i,
  input  logic [ADDR_W-1:0]   client_addr_i,
  input  logic [CNT_W-1:0]    buf_depth_i,
  input  logic                peer_ready_i,
  input  logic                grant_i,
  input  logic                expire_i,
  input  logic                take_i,
  output seq_state_t          state_o,
  output logic [CNT_W-1:0]    need_o,
  output logic                hdr_wr_o,
  output logic [SLOT_W-1:0]   hdr_word_o,
  output logic                last_byte_o,
  output logic                ok_o
);

  seq_state_t               state_q;
  logic [LEN_W-1:0]         rem_q;
  logic [LEN_FIELD_W-1:0]   cap_q;
  logic [LEN_FIELD_W-1:0]   left_q;
  logic [SLOT_W-1:0]        hdr_q;
  logic [ADDR_W-1:0]        host_q;
  logic [ADDR_W-1:0]        client_q;
  logic                     ok_q;

  logic [LEN_FIELD_W-1:0]   start_cap;
  logic                     rem_fits;
  logic [LEN_FIELD_W-1:0]   frag_len;

  assign start_cap = frag_cap(16'(buf_depth_i));
  assign rem_fits  = rem_q <= LEN_W'(cap_q);
  assign frag_len  = rem_fits ? rem_q[LEN_FIELD_W-1:0] : cap_q;

  assign state_o     = state_q;
  assign need_o      = (state_q == ST_WAIT_PAY) ? CNT_W'(slots_for(left_q)) : CNT_W'(1);
  assign hdr_wr_o    = (state_q == ST_HDR);
  assign hdr_word_o  = hdr_q;
  assign last_byte_o = (left_q == LEN_FIELD_W'(1));
  assign ok_o        = ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      rem_q    <= '0;
      cap_q    <= '0;
      left_q   <= '0;
      hdr_q    <= '0;
      host_q   <= '0;
      client_q <= '0;
      ok_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            ok_q     <= 1'b0;
            rem_q    <= msg_len_i;
            cap_q    <= start_cap;
            host_q   <= host_addr_i;
            client_q <= client_addr_i;
            if (msg_len_i == '0 || start_cap == '0) state_q <= ST_DONE;
            else                                    state_q <= ST_WAIT_HDR;
          end
        end
        ST_WAIT_HDR: begin
          if (grant_i) begin
            left_q  <= frag_len;
            hdr_q   <= build_header(rem_fits, frag_len, host_q, client_q);
            state_q <= ST_HDR;
          end else if (expire_i) begin
            state_q <= ST_DONE;
          end
        end
        ST_HDR: begin
          rem_q   <= rem_q - LEN_W'(left_q);
          state_q <= ST_WAIT_PAY;
        end
        ST_WAIT_PAY: begin
          if (grant_i)       state_q <= ST_PAY;
          else if (expire_i) state_q <= ST_DONE;
        end
        ST_PAY: begin
          if (take_i) begin
            left_q <= left_q - 1'b1;
            if (left_q == LEN_FIELD_W'(1)) state_q <= ST_IRQ;
          end
        end
        ST_IRQ: state_q <= ST_CHECK;
        ST_CHECK: begin
          if (!peer_ready_i) begin
            state_q <= ST_DONE;
          end else if (rem_q == '0) begin
            ok_q    <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_WAIT_HDR;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/msg_frag_tx.sv
module msg_frag_tx
  import mft_pkg::*;
#(
  parameter int LEN_W         = 16,
  parameter int CNT_W         = 8,
  parameter int POLL_INTERVAL = 10000,
  parameter int TIMEOUT_POLLS = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  msg_len_i,
  input  logic [7:0]        host_addr_i,
  input  logic [7:0]        client_addr_i,
  input  logic [CNT_W-1:0]  buf_depth_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_data_i,
  output logic              byte_ready_o,
  input  logic [CNT_W-1:0]  slot_free_i,
  input  logic              peer_ready_i,
  output logic              slot_wr_o,
  output logic [31:0]       slot_data_o,
  output logic              irq_gen_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              ok_o
);

  seq_state_t          state;
  logic [CNT_W-1:0]    need;
  logic                wait_active;
  logic                enough;
  logic                poll_evt;
  logic                grant;
  logic                expire;
  logic                hdr_wr;
  logic [SLOT_W-1:0]   hdr_word;
  logic                last_byte;
  logic                take;
  logic                word_wr;
  logic [SLOT_W-1:0]   word;
  logic                pay_en;
  logic                slot_wr_q;
  logic [SLOT_W-1:0]   slot_data_q;

  assign wait_active = (state == ST_WAIT_HDR) || (state == ST_WAIT_PAY);
  assign enough      = slot_free_i >= need;
  assign pay_en      = (state == ST_PAY);

  mft_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W)) seq_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .msg_len_i     (msg_len_i),
    .host_addr_i   (host_addr_i),
    .client_addr_i (client_addr_i),
    .buf_depth_i   (buf_depth_i),
    .peer_ready_i  (peer_ready_i),
    .grant_i       (grant),
    .expire_i      (expire),
    .take_i        (take),
    .state_o       (state),
    .need_o        (need),
    .hdr_wr_o      (hdr_wr),
    .hdr_word_o    (hdr_word),
    .last_byte_o   (last_byte),
    .ok_o          (ok_o)
  );

  mft_poll_timer #(.POLL_INTERVAL(POLL_INTERVAL), .TIMEOUT_POLLS(TIMEOUT_POLLS)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (wait_active),
    .enough_i (enough),
    .poll_o   (poll_evt),
    .grant_o  (grant),
    .expire_o (expire)
  );

  mft_packer packer_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (pay_en),
    .byte_valid_i (byte_valid_i),
    .byte_data_i  (byte_data_i),
    .last_i       (last_byte),
    .byte_ready_o (byte_ready_o),
    .take_o       (take),
    .word_wr_o    (word_wr),
    .word_o       (word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_wr_q   <= 1'b0;
      slot_data_q <= '0;
    end else begin
      slot_wr_q <= hdr_wr || word_wr;
      if (hdr_wr)       slot_data_q <= hdr_word;
      else if (word_wr) slot_data_q <= word;
    end
  end

  assign slot_wr_o   = slot_wr_q;
  assign slot_data_o = slot_data_q;
  assign irq_gen_o   = (state == ST_IRQ);
  assign busy_o      = (state != ST_IDLE);
  assign done_o      = (state == ST_DONE);

endmodule

// File: rtl/mft_checker.sv
module mft_checker #(
  parameter int LEN_W         = 16,
  parameter int POLL_INTERVAL = 10000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [LEN_W-1:0] msg_len_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             ok_o,
  input logic             irq_gen_o,
  input logic             slot_wr_o,
  input logic             byte_ready_o,
  input logic             peer_ready_i,
  input logic             poll_evt,
  input logic             grant,
  input logic             hdr_wr
);

  p_zero_len_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && msg_len_i == '0) |=> (done_o && !ok_o));

  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_gen_o |=> !irq_gen_o);

  p_irq_with_last_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_gen_o |-> slot_wr_o);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_ready_only_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready_o |-> busy_o);

  p_peer_loss_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_gen_o) && !peer_ready_i) |=> (done_o && !ok_o));

  p_hdr_after_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_wr |-> $past(grant));

  generate
    if (POLL_INTERVAL > 1) begin : g_gap
      p_poll_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        poll_evt |=> !poll_evt);
    end
  endgenerate

endmodule

bind msg_frag_tx mft_checker #(.LEN_W(LEN_W), .POLL_INTERVAL(POLL_INTERVAL)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .msg_len_i    (msg_len_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .ok_o         (ok_o),
  .irq_gen_o    (irq_gen_o),
  .slot_wr_o    (slot_wr_o),
  .byte_ready_o (byte_ready_o),
  .peer_ready_i (peer_ready_i),
  .poll_evt     (poll_evt),
  .grant        (grant),
  .hdr_wr       (hdr_wr)
);

// File: tb/msg_frag_tx_tb_top.sv
module msg_frag_tx_tb_top;

  localparam int P = 4;
  localparam int T = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] msg_len_i = '0;
  logic [7:0]  host_addr_i = '0;
  logic [7:0]  client_addr_i = '0;
  logic [7:0]  buf_depth_i = '0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_data_i = '0;
  logic        byte_ready_o;
  logic [7:0]  slot_free_i = 8'd255;
  logic        peer_cfg = 1'b1;
  logic        peer_dropped = 1'b0;
  logic        peer_ready_i;
  logic        slot_wr_o;
  logic [31:0] slot_data_o;
  logic        irq_gen_o;
  logic        busy_o;
  logic        done_o;
  logic        ok_o;

  assign peer_ready_i = peer_cfg && !peer_dropped;

  always #5 clk = ~clk;

  msg_frag_tx #(.LEN_W(16), .CNT_W(8), .POLL_INTERVAL(P), .TIMEOUT_POLLS(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .msg_len_i(msg_len_i),
    .host_addr_i(host_addr_i), .client_addr_i(client_addr_i), .buf_depth_i(buf_depth_i),
    .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i), .byte_ready_o(byte_ready_o),
    .slot_free_i(slot_free_i), .peer_ready_i(peer_ready_i), .slot_wr_o(slot_wr_o),
    .slot_data_o(slot_data_o), .irq_gen_o(irq_gen_o), .busy_o(busy_o),
    .done_o(done_o), .ok_o(ok_o)
  );

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;

  logic [7:0]  msg_mem [0:2047];
  int          feed_len = 0;
  int          feed_idx = 0;
  bit          take_pend = 0;
  bit          drop_on_irq = 0;
  int          clr_gen = 0;
  int          clr_seen = 0;

  logic [31:0] got_slots [0:1023];
  int          got_n = 0;
  int          irq_pos [0:511];
  int          irq_n = 0;
  bit          done_seen = 0;
  bit          ok_seen = 0;
  int          done_cyc = 0;
  int          start_cyc = 0;

  logic [31:0] exp_slots [0:1023];
  int          exp_n = 0;
  int          exp_irq [0:511];
  int          exp_frags = 0;

  task automatic chk(input bit cond, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!cond) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor and byte feeder; all sampling away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (clr_gen != clr_seen) begin
      clr_seen  = clr_gen;
      got_n     = 0;
      irq_n     = 0;
      done_seen = 0;
      ok_seen   = 0;
      feed_idx  = 0;
      take_pend = 0;
    end
    if (take_pend) feed_idx++;
    byte_valid_i = (feed_idx < feed_len);
    byte_data_i  = byte_valid_i ? msg_mem[feed_idx] : 8'h00;
    take_pend    = byte_valid_i && byte_ready_o;
    if (slot_wr_o && got_n < 1024) begin
      got_slots[got_n] = slot_data_o;
      got_n++;
    end
    if (!busy_o) peer_dropped = 0;
    if (irq_gen_o) begin
      if (irq_n < 512) irq_pos[irq_n] = got_n;
      irq_n++;
      if (drop_on_irq) peer_dropped = 1;
    end
    if (done_o) begin
      done_seen = 1;
      ok_seen   = ok_o;
      done_cyc  = cyc;
    end
    if (cyc > 190000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // Expected slot stream, computed from the requirement text.
  task automatic build_exp(input int len, input int depth, input logic [7:0] host,
                           input logic [7:0] client);
    int ring, cap, rem, pos, f, nslots;
    logic [31:0] w;
    ring = depth * 4;
    cap  = ((ring > 511) ? 511 : ring) - 4;
    rem = len; pos = 0; exp_n = 0; exp_frags = 0;
    while (rem > 0) begin
      f = (rem < cap) ? rem : cap;
      w = '0;
      w[31]    = (f == rem);
      w[24:16] = 9'(f);
      w[15:8]  = host;
      w[7:0]   = client;
      exp_slots[exp_n] = w; exp_n++;
      nslots = (f + 3) / 4;
      for (int s = 0; s < nslots; s++) begin
        w = '0;
        for (int b = 0; b < 4; b++)
          if (s * 4 + b < f) w[8*b +: 8] = msg_mem[pos + s * 4 + b];
        exp_slots[exp_n] = w; exp_n++;
      end
      exp_irq[exp_frags] = exp_n; exp_frags++;
      pos += f; rem -= f;
    end
  endtask

  task automatic fill_msg(input int len, input int pattern);
    for (int i = 0; i < len; i++)
      msg_mem[i] = (pattern == 0) ? 8'($urandom) : 8'(i * 7 + pattern);
  endtask

  task automatic start_msg(input int len, input int depth, input logic [7:0] host,
                           input logic [7:0] client);
    clr_gen++;
    feed_len = len;
    @(negedge clk);
    start_i       = 1'b1;
    msg_len_i     = 16'(len);
    buf_depth_i   = 8'(depth);
    host_addr_i   = host;
    client_addr_i = client;
    start_cyc     = cyc;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input int limit, input string tag);
    int n = 0;
    while (!done_seen && n < limit) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    chk(done_seen, tag, "done within limit", 32'(done_seen), 32'd1);
  endtask

  task automatic compare_all(input string tag);
    int first_bad = -1;
    chk(ok_seen == 1'b1, tag, "ok flag", 32'(ok_seen), 32'd1);
    chk(got_n == exp_n, tag, "slot count", 32'(got_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (first_bad < 0 && got_slots[i] !== exp_slots[i]) first_bad = i;
    if (first_bad >= 0)
      chk(1'b0, tag, $sformatf("slot %0d", first_bad), got_slots[first_bad], exp_slots[first_bad]);
    else
      chk(1'b1, tag, "slot data", 32'd0, 32'd0);
    chk(irq_n == exp_frags, tag, "request pulses", 32'(irq_n), 32'(exp_frags));
    for (int i = 0; i < exp_frags && i < irq_n; i++)
      if (irq_pos[i] != exp_irq[i])
        chk(1'b0, tag, $sformatf("request %0d position", i), 32'(irq_pos[i]), 32'(exp_irq[i]));
  endtask

  task automatic run_full(input int len, input int depth, input logic [7:0] host,
                          input logic [7:0] client, input string tag);
    build_exp(len, depth, host, client);
    start_msg(len, depth, host, client);
    wait_done(20000, tag);
    compare_all(tag);
  endtask

  initial begin
    void'($urandom(32'h1D2C3B4A));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: idle after reset
    chk(!busy_o && !slot_wr_o && !irq_gen_o && !done_o && !byte_ready_o, "R11",
        "reset state", {27'd0, busy_o, slot_wr_o, irq_gen_o, done_o, byte_ready_o}, 32'd0);

    // R9: zero length rejected at once
    start_msg(0, 16, 8'h01, 8'h02);
    wait_done(4, "R9");
    chk(!ok_seen && got_n == 0, "R9", "zero length fails, no slots", 32'(got_n), 32'd0);
    chk(done_cyc - start_cyc <= 2, "R9", "reject latency", 32'(done_cyc - start_cyc), 32'd1);

    // R2: depth 1 leaves no room, rejected
    fill_msg(8, 3);
    start_msg(8, 1, 8'h01, 8'h02);
    wait_done(4, "R2");
    chk(!ok_seen && got_n == 0, "R2", "depth 1 rejected", 32'(got_n), 32'd0);

    // R1 R6: five bytes, one whole slot and one padded slot
    fill_msg(5, 0);
    run_full(5, 16, 8'hA5, 8'h3C, "R1_R6");
    chk(got_slots[0] == {1'b1, 6'd0, 9'd5, 8'hA5, 8'h3C}, "R1", "header bits",
        got_slots[0], {1'b1, 6'd0, 9'd5, 8'hA5, 8'h3C});
    chk(got_slots[2] == {24'd0, msg_mem[4]}, "R6", "zero padded tail", got_slots[2], {24'd0, msg_mem[4]});

    // R2 R3: smallest ring, 4-byte fragments
    fill_msg(9, 11);
    run_full(9, 2, 8'h10, 8'h20, "R2_R3");
    chk(got_slots[0][31] == 1'b0 && got_slots[4][31] == 1'b1, "R3", "complete only on last",
        {got_slots[0][31], got_slots[4][31]}, 32'd1);

    // R2: cap at 511-4 with a large ring, exact and one over
    fill_msg(507, 0);
    run_full(507, 200, 8'h01, 8'h7F, "R2");
    fill_msg(508, 0);
    run_full(508, 200, 8'h02, 8'h7E, "R2");
    fill_msg(1014, 0);
    run_full(1014, 200, 8'h03, 8'h7D, "R3");
    fill_msg(61, 5);
    run_full(61, 16, 8'h04, 8'h05, "R2");

    // R4: no free slot, nothing written; then space appears
    fill_msg(7, 9);
    build_exp(7, 16, 8'h44, 8'h55);
    slot_free_i = 8'd0;
    start_msg(7, 16, 8'h44, 8'h55);
    repeat (8) @(negedge clk);
    chk(got_n == 0 && busy_o, "R4", "stalled before header", 32'(got_n), 32'd0);
    slot_free_i = 8'd255;
    wait_done(200, "R4");
    compare_all("R4");

    // R5: one free slot lets the header through, payload needs three
    fill_msg(12, 2);
    build_exp(12, 16, 8'h66, 8'h77);
    slot_free_i = 8'd1;
    start_msg(12, 16, 8'h66, 8'h77);
    repeat (12) @(negedge clk);
    chk(got_n == 1 && busy_o, "R5", "only header while short", 32'(got_n), 32'd1);
    slot_free_i = 8'd3;
    wait_done(200, "R5");
    compare_all("R5");
    slot_free_i = 8'd255;

    // R10: timeout after T failed polls spaced P apart
    slot_free_i = 8'd0;
    fill_msg(4, 1);
    start_msg(4, 16, 8'h01, 8'h01);
    wait_done(200, "R10");
    chk(!ok_seen && got_n == 0, "R10", "timeout fails without writes", 32'(got_n), 32'd0);
    chk((done_cyc - start_cyc) >= (T - 1) * P && (done_cyc - start_cyc) <= (T - 1) * P + 4,
        "R10", "timeout latency", 32'(done_cyc - start_cyc), 32'((T - 1) * P + 2));
    slot_free_i = 8'd255;

    // R8: peer drops after first fragment
    fill_msg(100, 0);
    drop_on_irq = 1;
    start_msg(100, 8, 8'h09, 8'h0A);
    wait_done(2000, "R8");
    repeat (10) @(negedge clk);
    chk(!ok_seen, "R8", "fail flag", 32'(ok_seen), 32'd0);
    chk(got_n == 8 && irq_n == 1, "R8", "one fragment only", 32'(got_n), 32'd8);
    drop_on_irq = 0;

    // R7 R11: done pulse and request placement under random traffic
    for (int k = 0; k < 20; k++) begin
      int len, depth;
      len   = 1 + int'($urandom % 600);
      depth = 2 + int'($urandom % 199);
      fill_msg(len, 0);
      run_full(len, depth, 8'($urandom), 8'($urandom), "R7");
    end
    @(negedge clk);
    chk(!busy_o && !done_o, "R11", "idle after sends", {30'd0, busy_o, done_o}, 32'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule